// File: doc/BRIEF.md
# BFloat16 Activation Clamp Stage

This block sits in the packer output path and applies a simple activation to a stream of bfloat16 values, one value per beat. A 4-bit operation code taken from a 32-bit configuration word picks the operation: leave the value alone, rectify it (ReLU), force values under a threshold to zero, or saturate values over a threshold to the threshold. The 16-bit threshold comes from the same configuration word and is itself a bfloat16 number.

All comparisons work on the raw bfloat16 bit patterns, using sign-magnitude ordering, so no floating-point unit is involved. NaN inputs are never altered. The stage has one input and one output valid/ready stream. It holds one register of data, adds exactly one cycle of latency and obeys backpressure in full. The configuration word is sampled in the cycle a beat is accepted, so a change only affects beats accepted afterwards.

Top module: `bf16_act_stage`

## Requirements
- R1: The operation code is read from `cfg_word[5:2]` and the threshold from `cfg_word[21:6]`. Bits [1:0] (the zero-flag disables for source and destination) and bits [31:22] have no effect on the output.
- R2: Code 0 (off) and every code from 4 to 15 pass the value through unchanged.
- R3: Code 1 (ReLU) turns any non-NaN value whose bit 15 is set into 0x0000, and that includes negative zero and negative infinity. Every other value passes unchanged.
- R4: Code 2 (threshold minimum) turns a non-NaN value that orders strictly below the threshold into 0x0000. Values equal to or above the threshold pass unchanged.
- R5: Code 3 (threshold maximum) replaces a non-NaN value that orders strictly above the threshold with the threshold pattern. Values equal to or below the threshold pass unchanged.
- R6: The ordering is sign-magnitude on the bit pattern. A value with bit 15 clear is ordered by bits [14:0] ascending. A value with bit 15 set is ordered below every value with bit 15 clear, and among such values a larger [14:0] orders lower. Negative zero (0x8000) therefore orders just below positive zero (0x0000).
- R7: A NaN input passes unchanged in every mode. A NaN has bits [14:7] all ones and bits [6:0] not zero.
- R8: A beat accepted at a clock edge (`in_valid` and `in_ready` both high) appears on `out_data` with `out_valid` high right after that edge. It is computed from the configuration word present at that edge.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. A beat taken by the consumer with no new beat accepted drops `out_valid`.
- R10: While `rst_n` is low and right after it is released, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Configuration word: operation code [5:2], threshold [21:6] |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Stage can accept a beat |
| in_data | input | 16 | Input bfloat16 value |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer accepts the output beat |
| out_data | output | 16 | Output bfloat16 value after the activation |

## Verification
The bench targets the places where a bit-pattern comparison goes wrong. If negative values were compared as unsigned numbers, a negative threshold would be inverted and -3 would pass a -2 minimum. If negative zero were treated as positive, it would survive ReLU. If equality were treated as crossing the threshold, a value equal to the threshold would be zeroed or rewritten. NaN patterns and negative infinity separate a design that tests only the sign bit from one that recognises NaN. A long phase with random backpressure and random configuration changes exposes a stage that drops or repeats beats under stall, or that uses the configuration from the wrong cycle.

// File: rtl/bfact_pkg.sv
package bfact_pkg;

  localparam int BF_W     = 16;
  localparam int BF_EXP_W = 8;
  localparam int BF_MAN_W = 7;

  typedef logic [BF_W-1:0] bf16_t;

  typedef enum logic [1:0] {
    ACT_PASS = 2'd0,
    ACT_RELU = 2'd1,
    ACT_TMIN = 2'd2,
    ACT_TMAX = 2'd3
  } act_op_e;

  // Exponent all ones with a nonzero mantissa.
  function automatic logic bf_is_nan(bf16_t v);
    return (&v[BF_W-2 -: BF_EXP_W]) && (|v[BF_MAN_W-1:0]);
  endfunction

  // Map a bit pattern onto an unsigned key that follows sign-magnitude order.
  function automatic bf16_t bf_order_key(bf16_t v);
    return v[BF_W-1] ? ~v : {1'b1, v[BF_W-2:0]};
  endfunction

endpackage

// File: rtl/bfact_cfg_decode.sv
module bfact_cfg_decode
  import bfact_pkg::*;
#(
  parameter int CFG_W    = 32,
  parameter int MODE_LSB = 2,
  parameter int MODE_W   = 4,
  parameter int THR_LSB  = 6
) (
  input  logic [CFG_W-1:0] cfg_word,
  output act_op_e          op,
  output bf16_t            thr
);

  localparam int MODE_MSB = MODE_LSB + MODE_W - 1;
  localparam int THR_MSB  = THR_LSB + BF_W - 1;

  logic [MODE_W-1:0] mode_code;
  logic [CFG_W-1:0]  unused_cfg_bits;

  assign mode_code       = cfg_word[MODE_MSB:MODE_LSB];
  assign thr             = cfg_word[THR_MSB:THR_LSB];
  assign unused_cfg_bits = cfg_word;

  // Codes beyond the defined set fall back to pass-through.
  always_comb begin
    case (mode_code)
      MODE_W'(1): op = ACT_RELU;
      MODE_W'(2): op = ACT_TMIN;
      MODE_W'(3): op = ACT_TMAX;
      default:    op = ACT_PASS;
    endcase
  end

endmodule

// File: rtl/bfact_cmp.sv
module bfact_cmp
  import bfact_pkg::*;
(
  input  bf16_t a,
  input  bf16_t b,
  output logic  a_lt_b,
  output logic  a_gt_b
);

  bf16_t key_a;
  bf16_t key_b;

  assign key_a  = bf_order_key(a);
  assign key_b  = bf_order_key(b);
  assign a_lt_b = key_a < key_b;
  assign a_gt_b = key_a > key_b;

endmodule

// File: rtl/bfact_apply.sv
module bfact_apply
  import bfact_pkg::*;
(
  input  act_op_e op,
  input  bf16_t   thr,
  input  bf16_t   din,
  output bf16_t   dout
);

  logic below_thr;
  logic above_thr;
  logic din_nan;

  bfact_cmp u_cmp (
    .a      (din),
    .b      (thr),
    .a_lt_b (below_thr),
    .a_gt_b (above_thr)
  );

  assign din_nan = bf_is_nan(din);

  always_comb begin
    dout = din;
    if (!din_nan) begin
      case (op)
        ACT_RELU: if (din[BF_W-1]) dout = '0;
        ACT_TMIN: if (below_thr)   dout = '0;
        ACT_TMAX: if (above_thr)   dout = thr;
        default:  dout = din;
      endcase
    end
  end

endmodule

// File: rtl/bfact_pipe_reg.sv
module bfact_pipe_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic valid_q;
  logic valid_d;
  logic load_en;
  logic [W-1:0] data_q;

  assign in_ready = !valid_q || out_ready;
  assign load_en  = in_valid && in_ready;

  always_comb begin
    valid_d = valid_q;
    if (load_en)        valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) data_q <= in_data;
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

  a_r9_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r8_accept_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r9_drain_when_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  a_r8_data_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_data == $past(in_data)));

endmodule

// File: rtl/bf16_act_stage.sv
module bf16_act_stage
  import bfact_pkg::*;
#(
  parameter int CFG_W    = 32,
  parameter int MODE_LSB = 2,
  parameter int MODE_W   = 4,
  parameter int THR_LSB  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BF_W-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BF_W-1:0]  out_data
);

  act_op_e op;
  bf16_t   thr;
  bf16_t   act_res;

  bfact_cfg_decode #(
    .CFG_W    (CFG_W),
    .MODE_LSB (MODE_LSB),
    .MODE_W   (MODE_W),
    .THR_LSB  (THR_LSB)
  ) u_decode (
    .cfg_word (cfg_word),
    .op       (op),
    .thr      (thr)
  );

  bfact_apply u_apply (
    .op   (op),
    .thr  (thr),
    .din  (in_data),
    .dout (act_res)
  );

  bfact_pipe_reg #(
    .W (BF_W)
  ) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (act_res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  // Rectified results never carry a sign bit unless the input was NaN.
  a_r3_relu_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == ACT_RELU && !bf_is_nan(in_data)) |-> !act_res[BF_W-1]);

  // Saturated results never order above the threshold.
  a_r5_max_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == ACT_TMAX && !bf_is_nan(in_data))
      |-> (bf_order_key(act_res) <= bf_order_key(thr)));

  a_r7_nan_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && bf_is_nan(in_data)) |-> (act_res == in_data));

  a_r10_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

endmodule

// File: tb/bf16_act_stage_test.sv
module bf16_act_stage_test;

  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 4000;

  logic        clk;
  logic        rst_n;
  logic [31:0] cfg_word;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_data;
  logic        out_valid;
  logic        out_ready;
  logic [15:0] out_data;

  int checks;
  int fails;
  bit finished;

  bf16_act_stage uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_word  (cfg_word),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [31:0] mk_cfg(int mode, logic [15:0] thr,
                                         logic [9:0] hi, logic [1:0] lo);
    return {hi, thr, mode[3:0], lo};
  endfunction

  function automatic int ordv(logic [15:0] v);
    if (v[15]) return -int'(v[14:0]) - 1;
    return int'(v[14:0]);
  endfunction

  function automatic bit nanv(logic [15:0] v);
    return (v[14:7] == 8'hFF) && (v[6:0] != 0);
  endfunction

  function automatic logic [15:0] ref_out(logic [31:0] cfg, logic [15:0] v);
    int mode;
    logic [15:0] t;
    mode = int'(cfg[5:2]);
    t    = cfg[21:6];
    if (nanv(v)) return v;
    if (mode == 1) return v[15] ? 16'h0000 : v;
    if (mode == 2) return (ordv(v) < ordv(t)) ? 16'h0000 : v;
    if (mode == 3) return (ordv(v) > ordv(t)) ? t : v;
    return v;
  endfunction

  // Drives one beat with the consumer ready, then checks latency, value and drain.
  task automatic one_beat(logic [31:0] cfg, logic [15:0] din,
                          logic [15:0] exp, string req);
    @(negedge clk);
    cfg_word  = cfg;
    in_data   = din;
    in_valid  = 1'b1;
    out_ready = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R9 ready when empty", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_word = ~cfg;
    chk(out_valid == 1'b1, "R8 one-cycle latency", out_valid, 1);
    chk(out_data == exp, req, out_data, exp);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 drain after take", out_valid, 0);
  endtask

  logic [15:0] pick_vals [12];

  initial begin
    checks = 0; fails = 0; finished = 0;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_data = '0; cfg_word = '0;
    pick_vals = '{16'h0000, 16'h8000, 16'h3F80, 16'hBF80, 16'h4000, 16'hC000,
                  16'h7F80, 16'hFF80, 16'h7FC0, 16'hFFC1, 16'h0001, 16'h8001};
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10 valid low in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R10 ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 valid low after reset", out_valid, 0);

    // R2 pass-through codes
    one_beat(mk_cfg(0, 16'h3F80, 10'h000, 2'b00), 16'hC040, 16'hC040, "R2 mode0");
    one_beat(mk_cfg(7, 16'h3F80, 10'h000, 2'b00), 16'hBF80, 16'hBF80, "R2 mode7");
    one_beat(mk_cfg(15, 16'h4000, 10'h000, 2'b00), 16'h4040, 16'h4040, "R2 mode15");
    // R3 ReLU
    one_beat(mk_cfg(1, 16'h0000, 10'h000, 2'b00), 16'hBF80, 16'h0000, "R3 negative");
    one_beat(mk_cfg(1, 16'h0000, 10'h000, 2'b00), 16'h8000, 16'h0000, "R3 neg zero");
    one_beat(mk_cfg(1, 16'h0000, 10'h000, 2'b00), 16'h4000, 16'h4000, "R3 positive");
    one_beat(mk_cfg(1, 16'h0000, 10'h000, 2'b00), 16'hFF80, 16'h0000, "R3 neg inf");
    // R4 threshold minimum
    one_beat(mk_cfg(2, 16'h3F80, 10'h000, 2'b00), 16'h3F00, 16'h0000, "R4 below");
    one_beat(mk_cfg(2, 16'h3F80, 10'h000, 2'b00), 16'h3F80, 16'h3F80, "R4 equal");
    one_beat(mk_cfg(2, 16'h3F80, 10'h000, 2'b00), 16'h4000, 16'h4000, "R4 above");
    one_beat(mk_cfg(2, 16'hC000, 10'h000, 2'b00), 16'hBF80, 16'hBF80, "R4 R6 neg thr above");
    one_beat(mk_cfg(2, 16'hC000, 10'h000, 2'b00), 16'hC040, 16'h0000, "R4 R6 neg thr below");
    // R5 threshold maximum
    one_beat(mk_cfg(3, 16'h3F80, 10'h000, 2'b00), 16'h4000, 16'h3F80, "R5 above");
    one_beat(mk_cfg(3, 16'h3F80, 10'h000, 2'b00), 16'h3F80, 16'h3F80, "R5 equal");
    one_beat(mk_cfg(3, 16'h3F80, 10'h000, 2'b00), 16'hC0A0, 16'hC0A0, "R5 below");
    one_beat(mk_cfg(3, 16'hC000, 10'h000, 2'b00), 16'hBF80, 16'hC000, "R5 R6 neg thr");
    // R6 signed zeros
    one_beat(mk_cfg(2, 16'h0000, 10'h000, 2'b00), 16'h8000, 16'h0000, "R6 neg zero below pos zero");
    one_beat(mk_cfg(3, 16'h8000, 10'h000, 2'b00), 16'h0000, 16'h8000, "R6 pos zero above neg zero");
    // R7 NaN
    one_beat(mk_cfg(1, 16'h0000, 10'h000, 2'b00), 16'hFFC1, 16'hFFC1, "R7 relu nan");
    one_beat(mk_cfg(3, 16'h3F80, 10'h000, 2'b00), 16'h7FC0, 16'h7FC0, "R7 max nan");
    one_beat(mk_cfg(2, 16'h7F80, 10'h000, 2'b00), 16'h7F81, 16'h7F81, "R7 min nan");
    // R1 ignored bits
    one_beat(mk_cfg(2, 16'h3F80, 10'h3FF, 2'b11), 16'h3F00, 16'h0000, "R1 junk bits min");
    one_beat(mk_cfg(3, 16'h3F80, 10'h2A5, 2'b01), 16'h4000, 16'h3F80, "R1 junk bits max");
    one_beat(mk_cfg(0, 16'h3F80, 10'h3FF, 2'b10), 16'hBF80, 16'hBF80, "R1 junk bits pass");

    // Random stream with backpressure against a behavioural model (R8, R9 and all modes).
    begin
      bit          mvalid;
      logic [15:0] mdata;
      mvalid = 1'b0;
      mdata  = '0;
      for (int cyc = 0; cyc < RAND_CYCLES; cyc++) begin
        @(negedge clk);
        chk(out_valid == mvalid, "R9 valid vs model", out_valid, mvalid);
        if (mvalid) chk(out_data == mdata, "R8 data vs model", out_data, mdata);
        in_valid  = ($urandom_range(0, 3) != 0);
        out_ready = ($urandom_range(0, 2) != 0);
        in_data   = ($urandom_range(0, 1) != 0) ? pick_vals[$urandom_range(0, 11)]
                                               : 16'($urandom);
        cfg_word  = mk_cfg($urandom_range(0, 15),
                           ($urandom_range(0, 1) != 0) ? pick_vals[$urandom_range(0, 11)]
                                                       : 16'($urandom),
                           10'($urandom), 2'($urandom));
        #1;
        chk(in_ready == (!mvalid || out_ready), "R9 ready rule", in_ready, (!mvalid || out_ready));
        if (in_valid && (!mvalid || out_ready)) begin
          mdata  = ref_out(cfg_word, in_data);
          mvalid = 1'b1;
        end else if (out_ready) begin
          mvalid = 1'b0;
        end
      end
    end
    wrap_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    wrap_up();
  end

endmodule